// File: doc/BRIEF.md
# Programmable Address Window Decoder

The decoder steers a 32-bit processor address to one of several target devices. It holds a bank of programmable windows. Each window has a base address, a size given as a mask of 64 KB units, a target code and an attribute code. Each incoming address is compared with every enabled window in parallel. The decoder reports the target and attribute of the window that matches, together with the address the device should see.

Lower-numbered windows can also carry remap registers. For these windows, the high address bits that the window selects are replaced by a programmed remap value. The upper half of a 64-bit device address comes from a second remap register. Windows without remap pass the address through unchanged. When no enabled window matches, the decoder raises a miss. Software programs the bank through a plain write-enable, address and data port. The lookup path is combinational from the address and the current register contents.

Top module: `addrwin_decoder`

## Requirements
- R1: After a synchronous active-high reset, every register reads as zero and every window is disabled. On a miss, `lk_miss`=1, `lk_hit`=0, target and attribute are 0, `lk_xaddr` equals `lk_addr`, and `lk_xaddr_hi` is 0.
- R2: A window matches when the enable bit is set and the address and base agree in every bit of [31:16] outside the size mask. With a mask of contiguous ones from bit 0, the window covers (mask+1)×64 KB, aligned on its own size.
- R3: A size mask of zero gives the smallest window, exactly 64 KB.
- R4: A window whose enable bit is clear never matches, whatever its base and mask.
- R5: When several windows match, the window with the lowest index supplies the result.
- R6: For a window with index below NUM_REMAP, the output address is built in two parts. In bits [31:16], the remap-low bits outside the mask are combined with the address bits under the mask. Bits [15:0] are the input bits. `lk_xaddr_hi` carries that window's remap-high register.
- R7: For a window with index NUM_REMAP or above, a match passes the address through unchanged and gives `lk_xaddr_hi`=0. Writes to its remap registers are ignored.
- R8: Address bits [15:0] always reach `lk_xaddr` unchanged.
- R9: Register writes are selected as follows. A write with `cfg_we`=1 at a clock edge updates one register, chosen by `cfg_addr`={window index, sel}. The sel values are 0 for control, 1 for base, 2 for remap low and 3 for remap high. The control register holds the enable in bit 0, the target in [7:4], the attribute in [15:8] and the size mask in [31:16]. A write takes effect from the next cycle.
- R10: A remap window whose remap-low register equals its base returns the input address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | IDX_W+2 | Window index and register select |
| cfg_wdata | input | 32 | Register write data |
| lk_addr | input | 32 | Address to decode |
| lk_hit | output | 1 | An enabled window matched |
| lk_miss | output | 1 | No enabled window matched |
| lk_target | output | 4 | Target code of the selected window |
| lk_attr | output | 8 | Attribute code of the selected window |
| lk_xaddr | output | 32 | Translated address, low word |
| lk_xaddr_hi | output | 32 | Translated address, high word |

## Verification
The bench builds the decoder with four windows, two of which have remap. This keeps both the remap and pass-through variants in play and makes overlapping windows easy to arrange. It sweeps the upper address half on a coarse grid and probes every window edge at base, last byte and one past. Expected results come from arithmetic on byte sizes rather than on masks. Reconfiguring windows in the middle of the run reaches priority between overlapping windows, the effect of the enable bit, and ignored remap writes.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;

    localparam int ADDR_W = 32;
    localparam int HALF_W = 16;
    localparam int TGT_W  = 4;
    localparam int ATTR_W = 8;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_BASE   = 2'd1,
        SEL_RMP_LO = 2'd2,
        SEL_RMP_HI = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [HALF_W-1:0] size_mask;
        logic [ATTR_W-1:0] attr;
        logic [TGT_W-1:0]  target;
        logic [2:0]        rsvd;
        logic              en;
    } win_ctrl_t;

    typedef struct packed {
        win_ctrl_t         ctrl;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] rmp_lo;
        logic [ADDR_W-1:0] rmp_hi;
    } win_cfg_t;

    typedef struct packed {
        logic              hit;
        logic [TGT_W-1:0]  target;
        logic [ATTR_W-1:0] attr;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] addr_hi;
    } win_res_t;

    function automatic logic upper_match(input logic [HALF_W-1:0] a,
                                         input logic [HALF_W-1:0] b,
                                         input logic [HALF_W-1:0] mask);
        return ((a ^ b) & ~mask) == '0;
    endfunction

    function automatic logic [HALF_W-1:0] splice_upper(input logic [HALF_W-1:0] rmp,
                                                       input logic [HALF_W-1:0] a,
                                                       input logic [HALF_W-1:0] mask);
        return (rmp & ~mask) | (a & mask);
    endfunction

endpackage

// File: rtl/addrwin_regs.sv
module addrwin_regs
    import addrwin_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 4,
    localparam int IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W+1:0]  wr_addr,
    input  logic [ADDR_W-1:0] wr_data,
    output win_cfg_t          cfg [NUM_WIN]
);

    logic [IDX_W-1:0] wr_idx;
    reg_sel_e         wr_sel;

    assign wr_idx = wr_addr[IDX_W+1:2];
    assign wr_sel = reg_sel_e'(wr_addr[1:0]);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic        slot_we;
        win_ctrl_t   ctrl_q;
        logic [ADDR_W-1:0] base_q;
        logic [ADDR_W-1:0] lo_q;
        logic [ADDR_W-1:0] hi_q;

        assign slot_we = wr_en && (wr_idx == IDX_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q <= '0;
                base_q <= '0;
            end else if (slot_we) begin
                if (wr_sel == SEL_CTRL) ctrl_q <= win_ctrl_t'(wr_data);
                if (wr_sel == SEL_BASE) base_q <= wr_data;
            end
        end

        if (w < NUM_REMAP) begin : g_remap
            always_ff @(posedge clk) begin
                if (rst) begin
                    lo_q <= '0;
                    hi_q <= '0;
                end else if (slot_we) begin
                    if (wr_sel == SEL_RMP_LO) lo_q <= wr_data;
                    if (wr_sel == SEL_RMP_HI) hi_q <= wr_data;
                end
            end
        end else begin : g_plain
            assign lo_q = '0;
            assign hi_q = '0;
        end

        assign cfg[w] = '{ctrl: ctrl_q, base: base_q, rmp_lo: lo_q, rmp_hi: hi_q};

        // R9: a control write lands on the next cycle
        p_ctrl_write_r9: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == {IDX_W'(w), 2'b00}) |=> (ctrl_q == win_ctrl_t'($past(wr_data))));
    end

endmodule

// File: rtl/addrwin_match.sv
module addrwin_match
    import addrwin_pkg::*;
#(
    parameter bit HAS_REMAP = 1'b1
) (
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output win_res_t          res
);

    logic [HALF_W-1:0] up_in;
    logic [HALF_W-1:0] up_out;
    logic [ADDR_W-1:0] hi_out;

    assign up_in = addr[ADDR_W-1:HALF_W];

    if (HAS_REMAP) begin : g_xlat
        assign up_out = splice_upper(cfg.rmp_lo[ADDR_W-1:HALF_W], up_in, cfg.ctrl.size_mask);
        assign hi_out = cfg.rmp_hi;
    end else begin : g_pass
        assign up_out = up_in;
        assign hi_out = '0;
    end

    assign res.hit     = cfg.ctrl.en &&
                         upper_match(up_in, cfg.base[ADDR_W-1:HALF_W], cfg.ctrl.size_mask);
    assign res.target  = cfg.ctrl.target;
    assign res.attr    = cfg.ctrl.attr;
    assign res.addr    = {up_out, addr[HALF_W-1:0]};
    assign res.addr_hi = hi_out;

endmodule

// File: rtl/addrwin_prio.sv
module addrwin_prio
    import addrwin_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  win_res_t           res [NUM_WIN],
    input  logic [ADDR_W-1:0]  addr,
    output win_res_t           pick,
    output logic [NUM_WIN-1:0] grant
);

    always_comb begin
        pick  = '{hit: 1'b0, target: '0, attr: '0, addr: addr, addr_hi: '0};
        grant = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (res[i].hit) begin
                pick  = res[i];
                grant = NUM_WIN'(1) << i;
            end
        end
    end

endmodule

// File: rtl/addrwin_decoder.sv
module addrwin_decoder
    import addrwin_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 4,
    localparam int IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W+1:0]  cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [31:0]       lk_addr,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [3:0]        lk_target,
    output logic [7:0]        lk_attr,
    output logic [31:0]       lk_xaddr,
    output logic [31:0]       lk_xaddr_hi
);

    win_cfg_t           cfg   [NUM_WIN];
    win_res_t           res   [NUM_WIN];
    win_res_t           pick;
    logic [NUM_WIN-1:0] grant;

    addrwin_regs #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .cfg     (cfg)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        addrwin_match #(.HAS_REMAP(w < NUM_REMAP)) u_match (
            .cfg  (cfg[w]),
            .addr (lk_addr),
            .res  (res[w])
        );

        // R4: a disabled window is never granted
        p_disabled_r4: assert property (@(posedge clk) disable iff (rst)
            !cfg[w].ctrl.en |-> !grant[w]);

        if (w >= NUM_REMAP) begin : g_pass_chk
            // R7: plain windows forward the address untouched
            p_passthru_r7: assert property (@(posedge clk) disable iff (rst)
                grant[w] |-> (lk_xaddr == lk_addr && lk_xaddr_hi == '0));
        end
    end

    addrwin_prio #(.NUM_WIN(NUM_WIN)) u_prio (
        .res   (res),
        .addr  (lk_addr),
        .pick  (pick),
        .grant (grant)
    );

    assign lk_hit      = pick.hit;
    assign lk_miss     = !pick.hit;
    assign lk_target   = pick.target;
    assign lk_attr     = pick.attr;
    assign lk_xaddr    = pick.addr;
    assign lk_xaddr_hi = pick.addr_hi;

    // R1: a miss carries neutral outputs
    p_miss_neutral_r1: assert property (@(posedge clk) disable iff (rst)
        lk_miss |-> (lk_target == '0 && lk_attr == '0 && lk_xaddr == lk_addr && lk_xaddr_hi == '0));

    // R5: at most one window is selected
    p_single_grant_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R8: page offset bits always pass through
    p_low_bits_r8: assert property (@(posedge clk) disable iff (rst)
        lk_xaddr[15:0] == lk_addr[15:0]);

endmodule

// File: tb/addrwin_decoder_tb.sv
module addrwin_decoder_tb;

    localparam int NW = 4;
    localparam int NR = 2;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [IW+1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   lk_addr = '0;
    logic          lk_hit, lk_miss;
    logic [3:0]    lk_target;
    logic [7:0]    lk_attr;
    logic [31:0]   lk_xaddr, lk_xaddr_hi;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_ctrl [NW];
    logic [31:0] m_base [NW];
    logic [31:0] m_lo   [NW];
    logic [31:0] m_hi   [NW];

    always #10 clk = ~clk;

    addrwin_decoder #(.NUM_WIN(NW), .NUM_REMAP(NR)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_target(lk_target),
        .lk_attr(lk_attr), .lk_xaddr(lk_xaddr), .lk_xaddr_hi(lk_xaddr_hi)
    );

    task automatic model_clear();
        for (int w = 0; w < NW; w++) begin
            m_ctrl[w] = '0; m_base[w] = '0; m_lo[w] = '0; m_hi[w] = '0;
        end
    endtask

    task automatic wr(input int idx, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {IW'(idx), 2'(sel)}; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: m_ctrl[idx] = d;
            1: m_base[idx] = d;
            2: if (idx < NR) m_lo[idx] = d;
            default: if (idx < NR) m_hi[idx] = d;
        endcase
    endtask

    task automatic chk(input string tag, input logic [31:0] a);
        logic [31:0] e_x, e_hi;
        logic [3:0]  e_t;
        logic [7:0]  e_a;
        logic        e_hit;
        longint      sz, lm;
        @(negedge clk);
        lk_addr = a;
        #1;
        e_hit = 0; e_t = 0; e_a = 0; e_x = a; e_hi = 0;
        for (int w = NW - 1; w >= 0; w--) begin
            sz = (longint'(m_ctrl[w][31:16]) + 1) * 65536;
            lm = sz - 1;
            if (m_ctrl[w][0] && ((longint'(a) & ~lm) == (longint'(m_base[w]) & ~lm))) begin
                e_hit = 1; e_t = m_ctrl[w][7:4]; e_a = m_ctrl[w][15:8];
                if (w < NR) begin
                    e_x  = 32'((longint'(m_lo[w]) & ~lm) | (longint'(a) & lm));
                    e_hi = m_hi[w];
                end else begin
                    e_x = a; e_hi = 0;
                end
            end
        end
        n_chk++;
        if (lk_hit !== e_hit || lk_miss !== !e_hit || lk_target !== e_t || lk_attr !== e_a ||
            lk_xaddr !== e_x || lk_xaddr_hi !== e_hi) begin
            n_fail++;
            $display("FAIL %s addr=%h: got hit=%b miss=%b tgt=%h attr=%h x=%h hi=%h exp hit=%b tgt=%h attr=%h x=%h hi=%h",
                     tag, a, lk_hit, lk_miss, lk_target, lk_attr, lk_xaddr, lk_xaddr_hi,
                     e_hit, e_t, e_a, e_x, e_hi);
        end
    endtask

    task automatic sweep(input string tag);
        for (int u = 0; u < 65536; u += 257) chk(tag, {16'(u), 16'h5A3C});
    endtask

    task automatic edges(input string tag, input int w);
        logic [31:0] sz, b;
        sz = (32'(m_ctrl[w][31:16]) + 1) << 16;
        b  = m_base[w] & ~(sz - 1);
        chk(tag, b);
        chk(tag, b + sz - 1);
        chk(tag, b + sz);
        chk(tag, b - 1);
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: everything misses out of reset
        sweep("R1");

        // window 0: 16 MB remapped, target 1 (R6)
        wr(0, 1, 32'h1000_0000);
        wr(0, 2, 32'h45AB_0000);
        wr(0, 3, 32'h0000_0007);
        wr(0, 0, {16'h00FF, 8'h11, 4'h1, 3'b000, 1'b1});
        // window 1: 256 MB overlapping window 0, remap equal to base (R10)
        wr(1, 1, 32'h1000_0000);
        wr(1, 2, 32'h1000_0000);
        wr(1, 0, {16'h0FFF, 8'h22, 4'h2, 3'b000, 1'b1});
        // window 2: 64 KB, no remap; remap writes ignored (R3, R7)
        wr(2, 1, 32'h2003_0000);
        wr(2, 2, 32'h7777_0000);
        wr(2, 3, 32'h0000_0009);
        wr(2, 0, {16'h0000, 8'h33, 4'h3, 3'b000, 1'b1});
        // window 3: configured but disabled (R4)
        wr(3, 1, 32'h3000_0000);
        wr(3, 2, 32'h5555_0000);
        wr(3, 0, {16'h00FF, 8'h44, 4'h4, 3'b000, 1'b0});

        sweep("R2");
        edges("R6", 0);
        edges("R5", 1);
        edges("R3", 2);
        edges("R4", 3);
        chk("R8", 32'h1012_FFFF);
        chk("R10", 32'h1ABC_1234);
        chk("R7", 32'h2003_8001);

        // R4: enabling window 3 makes it reachable
        wr(3, 0, {16'h00FF, 8'h44, 4'h4, 3'b000, 1'b1});
        edges("R4", 3);
        chk("R7", 32'h3042_0010);

        // R5: with window 0 off, window 1 serves its range
        wr(0, 0, {16'h00FF, 8'h11, 4'h1, 3'b000, 1'b0});
        edges("R5", 0);
        // R9: retarget window 1 via its control register
        wr(1, 0, {16'h0FFF, 8'hA5, 4'hC, 3'b000, 1'b1});
        chk("R9", 32'h1800_0000);
        // R6: a 4 GB remap window covers all addresses
        wr(0, 2, 32'h0000_0000);
        wr(0, 0, {16'hFFFF, 8'h11, 4'h1, 3'b000, 1'b1});
        chk("R6", 32'hDEAD_BEEF);
        chk("R6", 32'h0000_0001);

        // R1: reset clears everything again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        model_clear();
        sweep("R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout exp completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule